// File: doc/BRIEF.md
# Multi-Converter Capture Stream Packer

This block merges the stereo samples of several capture converters into one tagged stream on a serial input data line. Every converter carries its own configuration: a stream number, an even starting channel, a channel count field, a rate code and a sample format. Each frame, the converters whose stream number equals the selected target stream form a group. The group is checked for consistency. If the group passes and every member holds a fresh sample pair, the block sends a tag followed by the data block, one bit per bit clock.

Samples enter through one-entry valid/ready holding slots, one slot per converter. A frame either sends every channel of the group or sends nothing. A frame that is refused leaves the line low and keeps the held samples for a later frame.

Top module: `cap_stream_packer`

## Requirements
- R1: While rst_ni is low and after reset, sdi_o is 0 and every bit of smp_ready_o is 1.
- R2: A converter slot takes a left/right pair on a clock edge where valid and ready are both high. Ready then stays low and the pair stays unchanged until a frame that sends it. After that frame, ready is high again.
- R3: A converter belongs to the group when its stream number is non-zero and equals tgt_sid_i. If tgt_sid_i is 0, or no converter matches it, nothing is sent.
- R4: Each member's starting channel must be even and lower than the channel count field, and no two members may share a starting channel. Otherwise the frame is refused.
- R5: All members must agree on rate code, format code and channel count field. The channel count field plus one must equal twice the member count. Format code 3 is invalid. A frame that fails any of these checks is refused.
- R6: A sent frame begins with a 14-bit tag, MSB first: the 4-bit stream number, then a 10-bit length equal to channels × bytes per sample. A 16-bit sample counts 2 bytes; a 20-bit or 24-bit sample counts 3 bytes.
- R7: The data block sends one sample per channel in ascending channel order. A member's left sample sits on its starting channel and its right sample on the next channel. Format code 0, 1 or 2 selects 16, 20 or 24 bits, taken from the low bits of the input, MSB first.
- R8: frame_start_i is sampled on a rising edge. The first tag bit appears on sdi_o after that edge, and each later edge moves to the next bit. After the last data bit, sdi_o returns to 0.
- R9: If any member has no held sample at frame start, nothing is sent and no slot is emptied.
- R10: A frame_start_i that arrives while a frame is being sent is ignored.
- R11: A refused frame keeps sdi_o at 0 and empties no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame start strobe |
| tgt_sid_i | input | 4 | Stream number to assemble this frame |
| cfg_sid_i | input | N_CONV*4 | Per-converter stream number (0 = inactive) |
| cfg_chan_i | input | N_CONV*4 | Per-converter starting channel |
| cfg_nch_i | input | N_CONV*4 | Per-converter channel count minus one |
| cfg_rate_i | input | N_CONV*RATE_W | Per-converter rate code |
| cfg_fmt_i | input | N_CONV*2 | Per-converter format code (0:16, 1:20, 2:24 bit) |
| smp_valid_i | input | N_CONV | Sample pair valid |
| smp_ready_o | output | N_CONV | Slot can take a pair |
| smp_left_i | input | N_CONV*SW | Left samples, right-aligned |
| smp_right_i | input | N_CONV*SW | Right samples, right-aligned |
| sdi_o | output | 1 | Serial stream output |

## Verification
Several properties are checked on every cycle. A slot is only emptied while it holds a pair, and a held pair stays stable until it is consumed. A frame only starts while the serializer is idle, and the busy state only rises after a load. The slot pointer never passes the last channel of the frame. The bench scenarios are the only place where the checks that need exact values are made. These cover the consistency rules: odd, out-of-range or duplicate channels; rate, format or count mismatches; and an inactive target. They also cover the tag and length values, the swapped channel order, the truncation for each format, the all-or-nothing rule for missing samples, and the ignoring of a frame start that arrives while a frame is being sent.

// File: rtl/cap_pack_pkg.sv
package cap_pack_pkg;
  localparam int SID_W = 4;
  localparam int NCH_W = 4;
  localparam int LEN_W = 10;
  localparam int TAG_W = SID_W + LEN_W;

  typedef enum logic [1:0] {PH_IDLE, PH_TAG, PH_DATA} phase_e;

  function automatic int fmt_bits(input logic [1:0] f);
    case (f)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 0;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] fmt_bytes(input logic [1:0] f);
    case (f)
      2'd0:    return LEN_W'(2);
      2'd1:    return LEN_W'(3);
      2'd2:    return LEN_W'(3);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cap_cnv_slot.sv
module cap_cnv_slot #(
  parameter int SW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [SW-1:0] left_i,
  input  logic [SW-1:0] right_i,
  input  logic          consume_i,
  output logic          ready_o,
  output logic          full_o,
  output logic [SW-1:0] left_o,
  output logic [SW-1:0] right_o
);
  logic          full_q;
  logic [SW-1:0] left_q, right_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else if (consume_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q  <= 1'b1;
      left_q  <= left_i;
      right_q <= right_i;
    end
  end

  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign left_o  = left_q;
  assign right_o = right_q;

  // R9: a slot is only drained while it holds a pair
  a_r9_consume_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |-> full_q);
  // R2: a held pair stays put until consumed
  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !consume_i) |=> (full_q && $stable(left_q) && $stable(right_q)));
endmodule

// File: rtl/cap_grp_check.sv
module cap_grp_check
  import cap_pack_pkg::*;
#(
  parameter int N_CONV = 2,
  parameter int RATE_W = 4,
  parameter int SLOT_W = 3
) (
  input  logic [SID_W-1:0]  tgt_sid_i,
  input  logic [SID_W-1:0]  sid_i  [N_CONV],
  input  logic [NCH_W-1:0]  chan_i [N_CONV],
  input  logic [NCH_W-1:0]  nch_i  [N_CONV],
  input  logic [RATE_W-1:0] rate_i [N_CONV],
  input  logic [1:0]        fmt_i  [N_CONV],
  output logic [N_CONV-1:0] grp_o,
  output logic              ok_o,
  output logic [SLOT_W-1:0] nslot_o,
  output logic [1:0]        fmt_o,
  output logic [NCH_W-1:0]  nch_o
);
  always_comb begin
    int                cnt;
    logic              seen;
    logic [RATE_W-1:0] rate_ref;
    cnt      = 0;
    seen     = 1'b0;
    rate_ref = '0;
    fmt_o    = '0;
    nch_o    = '0;
    ok_o     = 1'b1;
    for (int i = 0; i < N_CONV; i++)
      grp_o[i] = (tgt_sid_i != '0) && (sid_i[i] == tgt_sid_i);
    // all members must share the first member's entries
    for (int i = 0; i < N_CONV; i++) begin
      if (grp_o[i]) begin
        cnt = cnt + 1;
        if (!seen) begin
          seen     = 1'b1;
          rate_ref = rate_i[i];
          fmt_o    = fmt_i[i];
          nch_o    = nch_i[i];
        end else if (rate_i[i] != rate_ref || fmt_i[i] != fmt_o || nch_i[i] != nch_o) begin
          ok_o = 1'b0;
        end
      end
    end
    // even, in range, no shared slot
    for (int i = 0; i < N_CONV; i++) begin
      if (grp_o[i]) begin
        if (chan_i[i][0] || chan_i[i] >= nch_o) ok_o = 1'b0;
        for (int j = 0; j < i; j++)
          if (grp_o[j] && chan_i[j] == chan_i[i]) ok_o = 1'b0;
      end
    end
    if (!seen) ok_o = 1'b0;
    if (int'(nch_o) + 1 != 2 * cnt) ok_o = 1'b0;
    if (fmt_o == 2'd3) ok_o = 1'b0;
    nslot_o = SLOT_W'(2 * cnt);
  end
endmodule

// File: rtl/cap_frame_ser.sv
module cap_frame_ser
  import cap_pack_pkg::*;
#(
  parameter int CH_MAX = 4,
  parameter int SW     = 24,
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SID_W-1:0]  sid_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SLOT_W-1:0] nslot_i,
  input  logic [1:0]        fmt_i,
  input  logic [SW-1:0]     slots_i [CH_MAX],
  output logic              sdi_o,
  output logic              busy_o
);
  localparam int MAXB   = (SW > TAG_W) ? SW : TAG_W;
  localparam int BIT_W  = $clog2(MAXB);
  localparam int SIDX_W = (CH_MAX > 1) ? $clog2(CH_MAX) : 1;

  phase_e             phase_q;
  logic [TAG_W-1:0]   tag_q;
  logic [SW-1:0]      slots_q [CH_MAX];
  logic [SW-1:0]      cur_q;
  logic [BIT_W-1:0]   bit_q, last_bit_q;
  logic [SIDX_W-1:0]  slot_q, last_slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      tag_q       <= '0;
      cur_q       <= '0;
      bit_q       <= '0;
      last_bit_q  <= '0;
      slot_q      <= '0;
      last_slot_q <= '0;
      for (int k = 0; k < CH_MAX; k++) slots_q[k] <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (load_i) begin
          phase_q     <= PH_TAG;
          tag_q       <= {sid_i, len_i};
          bit_q       <= '0;
          last_bit_q  <= BIT_W'(fmt_bits(fmt_i) - 1);
          last_slot_q <= SIDX_W'(nslot_i - 1'b1);
          // left-align each sample so the MSB leaves first
          for (int k = 0; k < CH_MAX; k++)
            slots_q[k] <= slots_i[k] << (SW - fmt_bits(fmt_i));
        end
        PH_TAG: begin
          if (bit_q == BIT_W'(TAG_W - 1)) begin
            phase_q <= PH_DATA;
            bit_q   <= '0;
            slot_q  <= '0;
            cur_q   <= slots_q[0];
          end else begin
            tag_q <= tag_q << 1;
            bit_q <= bit_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (bit_q == last_bit_q) begin
            bit_q <= '0;
            if (slot_q == last_slot_q) begin
              phase_q <= PH_IDLE;
            end else begin
              slot_q <= slot_q + 1'b1;
              cur_q  <= slots_q[slot_q + 1'b1];
            end
          end else begin
            cur_q <= cur_q << 1;
            bit_q <= bit_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_TAG:  sdi_o = tag_q[TAG_W-1];
      PH_DATA: sdi_o = cur_q[SW-1];
      default: sdi_o = 1'b0;
    endcase
  end

  assign busy_o = (phase_q != PH_IDLE);

  // R10: loads only reach an idle serializer
  a_r10_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (phase_q == PH_IDLE));
  // R8: activity always follows a load
  a_r8_rise_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_i));
  // R7: slot pointer stays within the frame
  a_r7_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA) |-> (slot_q <= last_slot_q));
endmodule

// File: rtl/cap_stream_packer.sv
module cap_stream_packer
  import cap_pack_pkg::*;
#(
  parameter int N_CONV = 2,
  parameter int SW     = 24,
  parameter int RATE_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_start_i,
  input  logic [3:0]               tgt_sid_i,
  input  logic [N_CONV*4-1:0]      cfg_sid_i,
  input  logic [N_CONV*4-1:0]      cfg_chan_i,
  input  logic [N_CONV*4-1:0]      cfg_nch_i,
  input  logic [N_CONV*RATE_W-1:0] cfg_rate_i,
  input  logic [N_CONV*2-1:0]      cfg_fmt_i,
  input  logic [N_CONV-1:0]        smp_valid_i,
  output logic [N_CONV-1:0]        smp_ready_o,
  input  logic [N_CONV*SW-1:0]     smp_left_i,
  input  logic [N_CONV*SW-1:0]     smp_right_i,
  output logic                     sdi_o
);
  localparam int CH_MAX = 2 * N_CONV;
  localparam int SLOT_W = $clog2(CH_MAX + 1);
  localparam int SIDX_W = (CH_MAX > 1) ? $clog2(CH_MAX) : 1;

  logic [SID_W-1:0]  sid_a  [N_CONV];
  logic [NCH_W-1:0]  chan_a [N_CONV];
  logic [NCH_W-1:0]  nch_a  [N_CONV];
  logic [RATE_W-1:0] rate_a [N_CONV];
  logic [1:0]        fmt_a  [N_CONV];
  logic [SW-1:0]     left_a [N_CONV];
  logic [SW-1:0]     right_a[N_CONV];
  logic [N_CONV-1:0] full, grp, consume;
  logic              ok, busy, fire;
  logic [SLOT_W-1:0] nslot;
  logic [1:0]        fmt;
  logic [NCH_W-1:0]  nch;
  logic [SW-1:0]     slots [CH_MAX];
  logic [LEN_W-1:0]  len;

  for (genvar g = 0; g < N_CONV; g++) begin : g_cnv
    assign sid_a[g]  = cfg_sid_i [g*SID_W  +: SID_W];
    assign chan_a[g] = cfg_chan_i[g*NCH_W  +: NCH_W];
    assign nch_a[g]  = cfg_nch_i [g*NCH_W  +: NCH_W];
    assign rate_a[g] = cfg_rate_i[g*RATE_W +: RATE_W];
    assign fmt_a[g]  = cfg_fmt_i [g*2      +: 2];

    cap_cnv_slot #(.SW(SW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (smp_valid_i[g]),
      .left_i    (smp_left_i [g*SW +: SW]),
      .right_i   (smp_right_i[g*SW +: SW]),
      .consume_i (consume[g]),
      .ready_o   (smp_ready_o[g]),
      .full_o    (full[g]),
      .left_o    (left_a[g]),
      .right_o   (right_a[g])
    );
  end

  cap_grp_check #(.N_CONV(N_CONV), .RATE_W(RATE_W), .SLOT_W(SLOT_W)) u_chk (
    .tgt_sid_i (tgt_sid_i),
    .sid_i     (sid_a),
    .chan_i    (chan_a),
    .nch_i     (nch_a),
    .rate_i    (rate_a),
    .fmt_i     (fmt_a),
    .grp_o     (grp),
    .ok_o      (ok),
    .nslot_o   (nslot),
    .fmt_o     (fmt),
    .nch_o     (nch)
  );

  // all-or-nothing: every member must hold a pair
  assign fire    = frame_start_i && !busy && ok && (&(full | ~grp));
  assign consume = fire ? grp : '0;
  assign len     = LEN_W'(nslot) * fmt_bytes(fmt);

  always_comb begin
    for (int k = 0; k < CH_MAX; k++) slots[k] = '0;
    for (int i = 0; i < N_CONV; i++) begin
      if (grp[i] && (int'(chan_a[i]) + 1 < CH_MAX)) begin
        slots[SIDX_W'(chan_a[i])]        = left_a[i];
        slots[SIDX_W'(chan_a[i]) + 1'b1] = right_a[i];
      end
    end
  end

  cap_frame_ser #(.CH_MAX(CH_MAX), .SW(SW), .SLOT_W(SLOT_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fire),
    .sid_i   (tgt_sid_i),
    .len_i   (len),
    .nslot_i (nslot),
    .fmt_i   (fmt),
    .slots_i (slots),
    .sdi_o   (sdi_o),
    .busy_o  (busy)
  );

  // R8: an accepted frame start makes the serializer busy on the next cycle
  a_r8_busy_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> busy);
endmodule

// File: tb/cap_stream_packer_tb_top.sv
module cap_stream_packer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        fs = 1'b0;
  logic [3:0]  tgt = '0;
  logic [3:0]  sid_a[2], chan_a[2], nch_a[2], rate_a[2];
  logic [1:0]  fmt_a[2];
  logic [23:0] l_a[2], r_a[2];
  logic [1:0]  vld = '0;
  logic [1:0]  rdy;
  logic        sdi;

  cap_stream_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .tgt_sid_i(tgt),
    .cfg_sid_i({sid_a[1], sid_a[0]}), .cfg_chan_i({chan_a[1], chan_a[0]}),
    .cfg_nch_i({nch_a[1], nch_a[0]}), .cfg_rate_i({rate_a[1], rate_a[0]}),
    .cfg_fmt_i({fmt_a[1], fmt_a[0]}), .smp_valid_i(vld), .smp_ready_o(rdy),
    .smp_left_i({l_a[1], l_a[0]}), .smp_right_i({r_a[1], r_a[0]}), .sdi_o(sdi)
  );

  int checks = 0, fails = 0;
  logic [127:0] exp_v;
  int exp_n;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int i, input logic [3:0] s, input logic [3:0] c,
                         input logic [3:0] n, input logic [3:0] r, input logic [1:0] f);
    sid_a[i] = s; chan_a[i] = c; nch_a[i] = n; rate_a[i] = r; fmt_a[i] = f;
  endtask

  task automatic push(input logic [1:0] m, input logic [23:0] l0, input logic [23:0] r0,
                      input logic [23:0] l1, input logic [23:0] r1);
    @(negedge clk);
    vld = m; l_a[0] = l0; r_a[0] = r0; l_a[1] = l1; r_a[1] = r1;
    @(negedge clk);
    vld = '0;
  endtask

  task automatic exp_clear(); exp_v = '0; exp_n = 0; endtask
  task automatic add_bits(input logic [23:0] v, input int w);
    for (int b = w - 1; b >= 0; b--) begin exp_v = (exp_v << 1) | 128'(v[b]); exp_n++; end
  endtask

  // drives a frame start, collects exp_n bits, then expects a silent tail
  task automatic run_frame(input string req, input int tail, input bit mid);
    logic [127:0] got = '0;
    int nz = 0;
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      got = (got << 1) | 128'(sdi);
      if (mid && i == 10) begin vld = 2'b11; l_a[0] = 24'h111111; r_a[0] = 24'h222222;
                                l_a[1] = 24'h333333; r_a[1] = 24'h444444; end
      if (mid && i == 11) vld = '0;
      if (mid && i == 20) fs = 1'b1;
      if (mid && i == 21) fs = 1'b0;
      @(negedge clk);
    end
    chk(got == exp_v, req, got, exp_v);
    for (int i = 0; i < tail; i++) begin
      if (sdi) nz++;
      @(negedge clk);
    end
    chk(nz == 0, {req, " tail low"}, 128'(nz), 0);
  endtask

  task automatic t_reset();
    chk(sdi == 1'b0, "R1 sdi", 128'(sdi), 0);
    chk(rdy == 2'b11, "R1 ready", 128'(rdy), 128'(2'b11));
  endtask

  task automatic t_basic();
    tgt = 4'd5;
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd1, 2'd2);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd1, 2'd2);
    push(2'b11, 24'hA5C3F1, 24'h0F0F0F, 24'h123456, 24'hFEDCBA);
    chk(rdy == 2'b00, "R2 held", 128'(rdy), 0);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd12, 10);
    add_bits(24'hA5C3F1, 24); add_bits(24'h0F0F0F, 24);
    add_bits(24'h123456, 24); add_bits(24'hFEDCBA, 24);
    run_frame("R6 R8 basic 24b", 20, 0);
    chk(rdy == 2'b11, "R2 consumed", 128'(rdy), 128'(2'b11));
  endtask

  task automatic t_swap();
    set_cfg(0, 4'd5, 4'd2, 4'd3, 4'd1, 2'd2);
    set_cfg(1, 4'd5, 4'd0, 4'd3, 4'd1, 2'd2);
    push(2'b11, 24'h000001, 24'h000002, 24'h800003, 24'h400004);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd12, 10);
    add_bits(24'h800003, 24); add_bits(24'h400004, 24);
    add_bits(24'h000001, 24); add_bits(24'h000002, 24);
    run_frame("R7 swapped order", 10, 0);
  endtask

  task automatic t_fmt();
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd2, 2'd0);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd2, 2'd0);
    push(2'b11, 24'hFF8001, 24'hEE7FFE, 24'hDDC3C3, 24'hCC0001);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd8, 10);
    add_bits(24'h8001, 16); add_bits(24'h7FFE, 16); add_bits(24'hC3C3, 16); add_bits(24'h0001, 16);
    run_frame("R7 R6 16-bit", 10, 0);
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd2, 2'd1);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd2, 2'd1);
    push(2'b11, 24'hF80001, 24'h07FFFF, 24'hA5A5A5, 24'h5A5A5A);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd12, 10);
    add_bits(24'h80001, 20); add_bits(24'h7FFFF, 20); add_bits(24'h5A5A5, 20); add_bits(24'hA5A5A, 20);
    run_frame("R7 R6 20-bit", 10, 0);
  endtask

  task automatic t_single();
    tgt = 4'd7;
    set_cfg(0, 4'd0, 4'd0, 4'd1, 4'd1, 2'd2);
    set_cfg(1, 4'd7, 4'd0, 4'd1, 4'd1, 2'd2);
    push(2'b10, 24'h0, 24'h0, 24'hC00FEE, 24'h0BEEF0);
    exp_clear(); add_bits(24'd7, 4); add_bits(24'd6, 10);
    add_bits(24'hC00FEE, 24); add_bits(24'h0BEEF0, 24);
    run_frame("R3 single member", 10, 0);
    chk(rdy == 2'b11, "R3 inactive slot untouched", 128'(rdy), 128'(2'b11));
  endtask

  task automatic t_odd();
    tgt = 4'd5;
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd1, 2'd2);
    set_cfg(1, 4'd5, 4'd1, 4'd3, 4'd1, 2'd2);
    push(2'b11, 24'h010203, 24'h040506, 24'h070809, 24'h0A0B0C);
    exp_clear(); run_frame("R4 odd channel", 120, 0);
    chk(rdy == 2'b00, "R11 samples kept", 128'(rdy), 0);
    set_cfg(1, 4'd5, 4'd0, 4'd3, 4'd1, 2'd2);
    exp_clear(); run_frame("R4 shared channel", 120, 0);
    set_cfg(1, 4'd5, 4'd4, 4'd3, 4'd1, 2'd2);
    exp_clear(); run_frame("R4 channel out of range", 120, 0);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd1, 2'd2);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd12, 10);
    add_bits(24'h010203, 24); add_bits(24'h040506, 24);
    add_bits(24'h070809, 24); add_bits(24'h0A0B0C, 24);
    run_frame("R11 held pair sent after fix", 10, 0);
  endtask

  task automatic t_mismatch();
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd1, 2'd2);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd2, 2'd2);
    push(2'b11, 24'hAAAAAA, 24'hBBBBBB, 24'hCCCCCC, 24'hDDDDDD);
    exp_clear(); run_frame("R5 rate mismatch", 120, 0);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd1, 2'd1);
    exp_clear(); run_frame("R5 format mismatch", 120, 0);
    set_cfg(0, 4'd5, 4'd0, 4'd1, 4'd1, 2'd2);
    set_cfg(1, 4'd5, 4'd2, 4'd1, 4'd1, 2'd2);
    exp_clear(); run_frame("R5 count field wrong", 120, 0);
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd1, 2'd3);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd1, 2'd3);
    exp_clear(); run_frame("R5 reserved format", 120, 0);
    chk(rdy == 2'b00, "R11 kept after refusals", 128'(rdy), 0);
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd1, 2'd2);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd1, 2'd2);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd12, 10);
    add_bits(24'hAAAAAA, 24); add_bits(24'hBBBBBB, 24);
    add_bits(24'hCCCCCC, 24); add_bits(24'hDDDDDD, 24);
    run_frame("R5 fixed config sends", 10, 0);
  endtask

  task automatic t_missing();
    push(2'b01, 24'h13579B, 24'h2468AC, 24'h0, 24'h0);
    exp_clear(); run_frame("R9 missing sample", 120, 0);
    chk(rdy == 2'b10, "R9 nothing consumed", 128'(rdy), 128'(2'b10));
    push(2'b10, 24'h0, 24'h0, 24'h0FACE0, 24'hBEAD00);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd12, 10);
    add_bits(24'h13579B, 24); add_bits(24'h2468AC, 24);
    add_bits(24'h0FACE0, 24); add_bits(24'hBEAD00, 24);
    run_frame("R9 complete set sent", 10, 0);
  endtask

  task automatic t_tgt0();
    tgt = 4'd0;
    set_cfg(0, 4'd0, 4'd0, 4'd3, 4'd1, 2'd2);
    set_cfg(1, 4'd0, 4'd2, 4'd3, 4'd1, 2'd2);
    push(2'b11, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF);
    exp_clear(); run_frame("R3 target zero", 120, 0);
    tgt = 4'd9;
    exp_clear(); run_frame("R3 no matching member", 120, 0);
    chk(rdy == 2'b00, "R3 slots kept", 128'(rdy), 0);
  endtask

  task automatic t_busy();
    tgt = 4'd0;
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    tgt = 4'd5;
    set_cfg(0, 4'd5, 4'd0, 4'd3, 4'd1, 2'd2);
    set_cfg(1, 4'd5, 4'd2, 4'd3, 4'd1, 2'd2);
    push(2'b11, 24'h987654, 24'h3210FE, 24'hDCBA98, 24'h765432);
    exp_clear(); add_bits(24'd5, 4); add_bits(24'd12, 10);
    add_bits(24'h987654, 24); add_bits(24'h3210FE, 24);
    add_bits(24'hDCBA98, 24); add_bits(24'h765432, 24);
    run_frame("R10 restart ignored", 60, 1);
    chk(rdy == 2'b00, "R10 new pair still held", 128'(rdy), 0);
  endtask

  initial begin
    set_cfg(0, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0);
    set_cfg(1, 4'd0, 4'd0, 4'd0, 4'd0, 2'd0);
    l_a[0] = '0; r_a[0] = '0; l_a[1] = '0; r_a[1] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_swap();
    t_fmt();
    t_single();
    t_odd();
    t_mismatch();
    t_missing();
    t_tgt0();
    t_busy();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule